// File: doc/BRIEF.md
# Gated Trip Output Driver

This block takes the held trip command and drives two relay outputs from it. One is a steady level for an electromechanical relay. The other is a square wave for a solid-state relay, made by dividing the system clock. Both drives are vetoed while the alarm is picked up. They are also vetoed while an undervoltage is present, which is when both active-low power-fail inputs are low. The undervoltage veto lasts for a fixed extension window after the supply recovers.

A trip indicator shows that an output was generated. In follow mode it tracks the unvetoed relay drive. In latch mode it stays lit after the trip ends, until a debounced press of the front-panel clear button. A blocked status output reports when any veto is in force.

Top module: `trip_out_gate`

## Requirements
- R1: While `trip_held_i` is high and no veto is in force, `emr_drv_o` is high in the same cycle; otherwise it is low.
- R2: `ssr_drv_o` is high only while `emr_drv_o` is high. From the first active cycle it is high for HALF_CYC cycles, then low for HALF_CYC cycles, and repeats. Every new active period restarts the pattern with the high half.
- R3: While `alarm_i` is high, `emr_drv_o`, `ssr_drv_o` and a follow-mode `trip_ind_o` are low, and `blocked_o` is high.
- R4: When both `pwr_fail_a_ni` and `pwr_fail_b_ni` are low, the outputs are vetoed. One low input alone does not veto.
- R5: After undervoltage clears, the veto stays in force for exactly EXT_CYC more cycles. Cycles 0 to EXT_CYC-1 after the release are blocked, and cycle EXT_CYC is free.
- R6: If undervoltage returns inside the extension window, the full EXT_CYC window restarts from its next release.
- R7: With `ind_latch_en_i` low (follow mode), `trip_ind_o` equals `emr_drv_o` in every cycle.
- R8: With `ind_latch_en_i` high, `trip_ind_o` stays high after an unvetoed trip ends. A debounced press of `clr_btn_i` clears it. A vetoed trip never sets it.
- R9: A press of `clr_btn_i` that lasts fewer than DB_CYC cycles after synchronisation is ignored, and the latched indicator stays lit.
- R10: `blocked_o` is high exactly when the alarm, undervoltage or its extension window is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_held_i | input | 1 | Held trip command |
| alarm_i | input | 1 | Alarm picked up, vetoes outputs |
| pwr_fail_a_ni | input | 1 | First supply monitor, low on failure |
| pwr_fail_b_ni | input | 1 | Second supply monitor, low on failure |
| ind_latch_en_i | input | 1 | 1 = latching indicator, 0 = follow mode |
| clr_btn_i | input | 1 | Front-panel indicator clear button, raw |
| emr_drv_o | output | 1 | Level drive for the electromechanical relay |
| ssr_drv_o | output | 1 | Square-wave drive for the solid-state relay |
| trip_ind_o | output | 1 | Trip indicator |
| blocked_o | output | 1 | Veto in force |

## Verification
The bench sweeps all sixteen combinations of trip, alarm and the two power-fail inputs. Each combination is given a clean extension window, so the sweep separates the veto of each source from the single-input case that must not veto. The square wave is sampled cycle by cycle over several periods, and an active period is restarted during the low half to show that it always restarts high. The extension is probed at its last blocked cycle and its first free cycle, both from a single release and after a relapse. Button pulses shorter and longer than the debounce window separate an ignored press from a real clear.

// File: rtl/trip_out_pkg.sv
package trip_out_pkg;
  typedef enum logic {
    IND_FOLLOW = 1'b0,
    IND_LATCH  = 1'b1
  } ind_mode_e;
endpackage

// File: rtl/trip_sq_div.sv
module trip_sq_div #(
  parameter int unsigned HALF_CYC = 3906
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sq_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  // idle holds phase high so each run starts on the high half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sq_o = run_i & ph_q;
endmodule

// File: rtl/trip_pf_ext.sv
module trip_pf_ext #(
  parameter int unsigned EXT_CYC = 150_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uv_i,
  output logic blk_o
);
  localparam int unsigned CW = $clog2(EXT_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(EXT_CYC);

  logic [CW-1:0] cnt_q;

  // reload while undervoltage persists; a relapse restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (uv_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign blk_o = uv_i | (cnt_q != '0);
endmodule

// File: rtl/trip_btn_clr.sv
module trip_btn_clr #(
  parameter int unsigned DB_CYC = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  output logic press_o
);
  localparam int unsigned CW = (DB_CYC > 1) ? $clog2(DB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_CYC - 1);

  logic [1:0]    sync_q;
  logic          state_q;
  logic          press_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      state_q <= 1'b0;
      press_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync_q  <= {sync_q[0], btn_i};
      press_q <= 1'b0;
      if (sync_q[1] == state_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        state_q <= sync_q[1];
        press_q <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;
endmodule

// File: rtl/trip_out_gate.sv
module trip_out_gate
  import trip_out_pkg::*;
#(
  parameter int unsigned HALF_CYC = 3906,
  parameter int unsigned EXT_CYC  = 150_000_000,
  parameter int unsigned DB_CYC   = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_held_i,
  input  logic alarm_i,
  input  logic pwr_fail_a_ni,
  input  logic pwr_fail_b_ni,
  input  logic ind_latch_en_i,
  input  logic clr_btn_i,
  output logic emr_drv_o,
  output logic ssr_drv_o,
  output logic trip_ind_o,
  output logic blocked_o
);
  logic      uv;
  logic      pf_blk;
  logic      active;
  logic      press;
  logic      ind_q;
  ind_mode_e mode;

  assign uv     = ~pwr_fail_a_ni & ~pwr_fail_b_ni;
  assign mode   = ind_mode_e'(ind_latch_en_i);

  trip_pf_ext #(.EXT_CYC(EXT_CYC)) u_pf_ext (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .uv_i  (uv),
    .blk_o (pf_blk)
  );

  assign blocked_o = alarm_i | pf_blk;
  assign active    = trip_held_i & ~blocked_o;

  trip_sq_div #(.HALF_CYC(HALF_CYC)) u_sq_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (active),
    .sq_o  (ssr_drv_o)
  );

  trip_btn_clr #(.DB_CYC(DB_CYC)) u_btn_clr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .btn_i  (clr_btn_i),
    .press_o(press)
  );

  // set wins over clear; follow mode keeps the latch empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ind_q <= 1'b0;
    else if (mode == IND_FOLLOW) ind_q <= 1'b0;
    else if (active)             ind_q <= 1'b1;
    else if (press)              ind_q <= 1'b0;
  end

  assign emr_drv_o  = active;
  assign trip_ind_o = (mode == IND_LATCH) ? (ind_q | active) : active;
endmodule

// File: rtl/trip_out_gate_chk.sv
module trip_out_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic trip_held_i,
  input logic alarm_i,
  input logic pwr_fail_a_ni,
  input logic pwr_fail_b_ni,
  input logic ind_latch_en_i,
  input logic emr_drv_o,
  input logic ssr_drv_o,
  input logic trip_ind_o,
  input logic blocked_o
);
  logic uv;
  logic armed_q;

  assign uv = !pwr_fail_a_ni && !pwr_fail_b_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_EMR_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_held_i && !blocked_o) |-> emr_drv_o); // R1
  AST_SSR_INSIDE_EMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ssr_drv_o |-> emr_drv_o); // R2
  AST_SSR_STARTS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(emr_drv_o) |-> ssr_drv_o); // R2
  AST_ALARM_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i |-> (blocked_o && !emr_drv_o && !ssr_drv_o)); // R3
  AST_UV_VETO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv |-> (blocked_o && !emr_drv_o)); // R4
  AST_EXT_AFTER_UV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(uv) && !uv) |-> blocked_o); // R5
  AST_FOLLOW_IND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ind_latch_en_i |-> (trip_ind_o == emr_drv_o)); // R7
  AST_BLOCK_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !alarm_i && !uv && !$past(uv) && !$past(blocked_o)) |-> !blocked_o); // R10
endmodule

bind trip_out_gate trip_out_gate_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trip_held_i   (trip_held_i),
  .alarm_i       (alarm_i),
  .pwr_fail_a_ni (pwr_fail_a_ni),
  .pwr_fail_b_ni (pwr_fail_b_ni),
  .ind_latch_en_i(ind_latch_en_i),
  .emr_drv_o     (emr_drv_o),
  .ssr_drv_o     (ssr_drv_o),
  .trip_ind_o    (trip_ind_o),
  .blocked_o     (blocked_o)
);

// File: tb/trip_out_gate_tb_top.sv
`timescale 1ns/1ps
module trip_out_gate_tb_top;
  localparam int HALF = 3;
  localparam int EXT  = 20;
  localparam int DB   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, alarm = 1'b0, pfa_n = 1'b1, pfb_n = 1'b1, latch_en = 1'b0, btn = 1'b0;
  logic emr, ssr, ind, blk;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trip_out_gate #(.HALF_CYC(HALF), .EXT_CYC(EXT), .DB_CYC(DB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trip_held_i(trip), .alarm_i(alarm),
    .pwr_fail_a_ni(pfa_n), .pwr_fail_b_ni(pfb_n), .ind_latch_en_i(latch_en),
    .clr_btn_i(btn), .emr_drv_o(emr), .ssr_drv_o(ssr), .trip_ind_o(ind), .blocked_o(blk)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    @(negedge clk);
    chk(emr, 1'b0, "reset emr"); chk(ssr, 1'b0, "reset ssr");
    chk(ind, 1'b0, "reset ind"); chk(blk, 1'b0, "reset blk");
    rst_n = 1'b1;
    tick(2);

    // R1 R3 R4 R7 R10: all combinations, clean extension each time
    for (int v = 0; v < 16; v++) begin
      logic t, a, fa, fb, uvx, e;
      {t, a, fa, fb} = 4'(v);
      trip = t; alarm = a; pfa_n = fa; pfb_n = fb;
      uvx = !fa && !fb;
      e = t && !a && !uvx;
      @(negedge clk);
      chk(emr, e, "R1 emr");
      chk(ind, e, "R7 ind follow");
      chk(blk, a || uvx, "R10 blk");
      if (a) chk(emr, 1'b0, "R3 alarm veto");
      if (!fa ^ !fb) chk(blk, a, "R4 single low");
      if (uvx) chk(emr, 1'b0, "R4 uv veto");
      tick();
      trip = 0; alarm = 0; pfa_n = 1; pfb_n = 1;
      tick(EXT + 2);
    end

    // R2: square wave from start, then restart in low half
    for (int rep = 0; rep < 2; rep++) begin
      trip = 1'b1;
      for (int k = 0; k < (rep == 0 ? 4 * HALF : HALF + 2); k++) begin
        @(negedge clk);
        chk(ssr, ((k / HALF) % 2) == 0, "R2 ssr phase");
        chk(emr, 1'b1, "R1 emr level");
        tick();
      end
      trip = 1'b0;
      @(negedge clk);
      chk(ssr, 1'b0, "R2 ssr idle");
      tick(2);
    end

    // R3 alarm mid-trip
    trip = 1'b1; alarm = 1'b1;
    @(negedge clk);
    chk(ssr, 1'b0, "R3 ssr veto"); chk(blk, 1'b1, "R3 blk");
    tick(); alarm = 1'b0;
    @(negedge clk);
    chk(emr, 1'b1, "R3 release"); chk(ssr, 1'b1, "R2 restart after veto");
    tick(); trip = 1'b0; tick();

    // R5 extension length
    trip = 1'b1; pfa_n = 0; pfb_n = 0; tick(3);
    pfa_n = 1; pfb_n = 1;
    for (int k = 0; k <= EXT; k++) begin
      @(negedge clk);
      if (k == 0 || k == EXT - 1) begin
        chk(blk, 1'b1, "R5 ext blocked"); chk(emr, 1'b0, "R5 emr held off");
      end
      if (k == EXT) begin
        chk(blk, 1'b0, "R5 ext end"); chk(emr, 1'b1, "R5 emr resumes");
      end
      tick();
    end

    // R6 relapse restarts window
    pfa_n = 0; pfb_n = 0; tick(2);
    pfa_n = 1; pfb_n = 1; tick(8);
    pfa_n = 0; pfb_n = 0; tick();
    pfa_n = 1; pfb_n = 1;
    for (int k = 0; k <= EXT; k++) begin
      @(negedge clk);
      if (k == EXT - 1) chk(blk, 1'b1, "R6 restarted window");
      if (k == EXT) chk(blk, 1'b0, "R6 window end");
      tick();
    end
    trip = 1'b0; tick(2);

    // R8 R9 latching indicator
    latch_en = 1'b1;
    alarm = 1'b1; trip = 1'b1; tick(2); trip = 1'b0; alarm = 1'b0; tick();
    @(negedge clk); chk(ind, 1'b0, "R8 vetoed trip no latch");
    tick();
    trip = 1'b1; tick(2); trip = 1'b0; tick(10);
    @(negedge clk); chk(ind, 1'b1, "R8 latched");
    tick();
    btn = 1'b1; tick(DB - 2); btn = 1'b0; tick(12);
    @(negedge clk); chk(ind, 1'b1, "R9 short press ignored");
    tick();
    btn = 1'b1; tick(DB + 8); btn = 1'b0; tick(DB + 8);
    @(negedge clk); chk(ind, 1'b0, "R8 cleared by press");
    tick();
    latch_en = 1'b0;
    @(negedge clk); chk(ind, 1'b0, "R7 follow idle");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule